// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that walks a linked list of transfer descriptors kept in a small on-block descriptor store. Each descriptor names a 16-bit source offset, a 16-bit destination offset, a byte count and the index of the descriptor that follows it. Per-descriptor flags control address stepping, byte-order reversal, automatic chaining, an early-termination input and a completion pulse. The channel configuration supplies the upper halves of both 32-bit addresses, the burst length, whether each burst needs its own request, the descriptor that starts the chain, and whether descriptor progress is kept apart from the stored copy.

Data moves over a byte-wide master port, one burst at a time. At the start of each burst the bus grant input must be high. The channel then reads the whole burst into a local buffer and writes it back out, with the byte order reversed if the descriptor asks for it. A rising edge on the request input starts work. A short pulse on the done output marks the end of each descriptor that asks for one.

Top module: `dmac_chan`

## Requirements
- R1: Every read address is {cfg_src_hi, source offset + byte position in burst} and every write address is {cfg_dst_hi, destination offset + byte position in burst}. Both lower halves wrap at 16 bits.
- R2: A descriptor is a 59-bit word written through dw_en/dw_idx/dw_data. Bit layout: [58:51] next index, [50:39] byte count, [38:23] source offset, [22:7] destination offset, bit 0 step source, bit 1 step destination, bit 2 swap enable, bit 3 swap group of four (clear: group of two), bit 4 auto-chain, bit 5 done-pulse enable, bit 6 termination-input enable.
- R3: A burst carries min(cfg_burst, remaining count) bytes, and a cfg_burst of 0 acts as 1. A burst starts only when bus_grant is high. Its reads occupy consecutive cycles, and its writes follow at once in consecutive cycles.
- R4: The remaining count falls by the burst length after each burst. A descriptor finishes when the count reaches zero, after writing exactly its byte count.
- R5: A request is a rising edge of req. When cfg_req_per_burst is 1, each burst after the first waits for a new request. When it is 0, one request runs every burst of the descriptor back to back.
- R6: After each burst, the source and destination offsets each advance by the burst length, each only if its step flag is set.
- R7: With swap enabled, each burst is written with its bytes reversed inside every aligned group of 2 or 4 bytes.
- R8: A next index of 0xFE ends the chain and re-arms the channel at cfg_init_desc. Any other next index selects the following descriptor. That descriptor starts at once if auto-chain is set, and otherwise on the next request.
- R9: With cfg_preserve at 1 the stored descriptor never changes, so a chain replays identically. With cfg_preserve at 0 the finished descriptor's final count and offsets are written back over it.
- R10: When a descriptor with done-pulse enable finishes, done is high for exactly two clock cycles.
- R11: With termination-input enable set, a rising edge on term_in during a burst's read or write cycles ends the descriptor after that burst.
- R12: A descriptor with count 0 finishes without any bus access and then follows its chaining rules.
- R13: While enable is low, there is no bus access, requests are discarded, and the chain position returns to cfg_init_desc.
- R14: After reset, mem_req and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable |
| req | input | 1 | Transfer request, acted on at its rising edge |
| term_in | input | 1 | Early-termination input, acted on at its rising edge |
| bus_grant | input | 1 | Permission to start a burst |
| cfg_src_hi | input | 16 | Upper half of the source address |
| cfg_dst_hi | input | 16 | Upper half of the destination address |
| cfg_burst | input | 7 | Burst length in bytes |
| cfg_req_per_burst | input | 1 | Each burst needs its own request |
| cfg_init_desc | input | IDX_W | First descriptor of the chain |
| cfg_preserve | input | 1 | Keep the stored descriptors unchanged |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | IDX_W | Descriptor write index |
| dw_data | input | 59 | Descriptor word |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| done | output | 1 | Descriptor completion pulse |

## Verification
Several properties are checked on every cycle: the upper address halves, back-to-back read and write addresses inside a burst, bus grant ahead of each burst, the write phase following the read phase directly, the burst-length bound, bus silence while disabled, and the exact two-cycle width of done. Other behaviour can only be shown by the bench's scenarios. These cover the byte reversal and address stepping seen in the destination image, the total byte count, request-per-burst pauses, chaining with and without auto-start, replay versus overwrite of descriptors, early termination, zero-count descriptors and discarded requests.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int BURST_W = 7;
  localparam int COUNT_W = 12;
  localparam logic [7:0] NEXT_END = 8'hFE;

  typedef struct packed {
    logic [7:0]         next;
    logic [COUNT_W-1:0] count;
    logic [15:0]        src_lo;
    logic [15:0]        dst_lo;
    logic               term_in_en;
    logic               term_out_en;
    logic               auto_next;
    logic               swap4;
    logic               swap_en;
    logic               inc_dst;
    logic               inc_src;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_CHECK, S_READ, S_WRITE, S_UPDATE, S_WAIT, S_FINISH
  } state_t;

  // Buffer position to read when writing byte i of a burst.
  function automatic logic [BURST_W-1:0] swap_index(
    input logic [BURST_W-1:0] i, input logic en, input logic four);
    logic [BURST_W-1:0] m;
    m = four ? BURST_W'(3) : BURST_W'(1);
    return en ? ((i & ~m) | (m - (i & m))) : i;
  endfunction

  // Bytes carried by the next burst.
  function automatic logic [BURST_W-1:0] burst_take(
    input logic [COUNT_W-1:0] remaining, input logic [BURST_W-1:0] burst);
    logic [BURST_W-1:0] eff;
    eff = (burst == '0) ? BURST_W'(1) : burst;
    return (remaining < COUNT_W'(eff)) ? BURST_W'(remaining) : eff;
  endfunction

endpackage

// File: rtl/dmac_desc_store.sv
module dmac_desc_store import dmac_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  desc_t            eng_data,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  desc_t            cfg_data,
  input  logic [IDX_W-1:0] rd_idx,
  output desc_t            rd_data
);
  desc_t entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (eng_we && eng_idx == IDX_W'(g))
        entry[g] <= eng_data;
      else if (cfg_we && cfg_idx == IDX_W'(g))
        entry[g] <= cfg_data;
    end
  end

  assign rd_data = entry[rd_idx];
endmodule

// File: rtl/dmac_burst_buf.sv
module dmac_burst_buf #(
  parameter int IDX_W = 7,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/dmac_pulse_stretch.sv
module dmac_pulse_stretch #(
  parameter int WIDTH = 2,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (trig)           left <= CNT_W'(WIDTH);
    else if (left != '0)     left <= left - CNT_W'(1);
  end

  assign pulse = (left != '0);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan import dmac_pkg::*; #(
  parameter int DESC_DEPTH = 16,
  parameter int DONE_WIDTH = 2,
  localparam int IDX_W = $clog2(DESC_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               req,
  input  logic               term_in,
  input  logic               bus_grant,
  input  logic [15:0]        cfg_src_hi,
  input  logic [15:0]        cfg_dst_hi,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic               cfg_req_per_burst,
  input  logic [IDX_W-1:0]   cfg_init_desc,
  input  logic               cfg_preserve,
  input  logic               dw_en,
  input  logic [IDX_W-1:0]   dw_idx,
  input  logic [DESC_W-1:0]  dw_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               done
);
  state_t             state;
  desc_t              wk;
  desc_t              st_rd;
  logic [IDX_W-1:0]   cur_idx;
  logic [BURST_W-1:0] k;
  logic [BURST_W-1:0] blen;
  logic               req_q, req_pend, term_q, term_hit;

  // Named internal events
  logic               req_edge, term_edge, take;
  logic               burst_last, desc_finish, chain_end, eng_we;
  logic [COUNT_W-1:0] remain_after;
  logic [BURST_W-1:0] rd_pos;

  assign req_edge     = req & ~req_q;
  assign term_edge    = term_in & ~term_q;
  assign take         = req_pend && ((state == S_IDLE) || (state == S_WAIT));
  assign burst_last   = (k == blen - BURST_W'(1));
  assign desc_finish  = (state == S_FINISH);
  assign chain_end    = desc_finish && (wk.next == NEXT_END);
  assign eng_we       = desc_finish && !cfg_preserve;
  assign remain_after = wk.count - COUNT_W'(blen);
  assign rd_pos       = swap_index(k, wk.swap_en, wk.swap4);

  dmac_desc_store #(.DEPTH(DESC_DEPTH)) u_store (
    .clk      (clk),
    .eng_we   (eng_we),
    .eng_idx  (cur_idx),
    .eng_data (wk),
    .cfg_we   (dw_en),
    .cfg_idx  (dw_idx),
    .cfg_data (desc_t'(dw_data)),
    .rd_idx   (cur_idx),
    .rd_data  (st_rd)
  );

  dmac_burst_buf #(.IDX_W(BURST_W)) u_buf (
    .clk     (clk),
    .wr_en   (state == S_READ),
    .wr_idx  (k),
    .wr_data (mem_rdata),
    .rd_idx  (rd_pos),
    .rd_data (mem_wdata)
  );

  dmac_pulse_stretch #(.WIDTH(DONE_WIDTH)) u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (desc_finish && wk.term_out_en),
    .pulse (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wk       <= '0;
      cur_idx  <= '0;
      k        <= '0;
      blen     <= BURST_W'(1);
      req_q    <= 1'b0;
      req_pend <= 1'b0;
      term_q   <= 1'b0;
      term_hit <= 1'b0;
    end else begin
      req_q  <= req;
      term_q <= term_in;
      if (!enable) begin
        state    <= S_IDLE;
        cur_idx  <= cfg_init_desc;
        req_pend <= 1'b0;
        term_hit <= 1'b0;
        k        <= '0;
      end else begin
        req_pend <= (req_pend & ~take) | req_edge;
        if (term_edge && wk.term_in_en && (state == S_READ || state == S_WRITE))
          term_hit <= 1'b1;
        unique case (state)
          S_IDLE: if (take) state <= S_LOAD;
          S_LOAD: begin
            wk       <= st_rd;
            term_hit <= 1'b0;
            state    <= S_CHECK;
          end
          S_CHECK: begin
            if (wk.count == '0) begin
              state <= S_FINISH;
            end else if (bus_grant) begin
              blen  <= burst_take(wk.count, cfg_burst);
              k     <= '0;
              state <= S_READ;
            end
          end
          S_READ: begin
            if (burst_last) begin
              k     <= '0;
              state <= S_WRITE;
            end else begin
              k <= k + BURST_W'(1);
            end
          end
          S_WRITE: begin
            if (burst_last) state <= S_UPDATE;
            else            k     <= k + BURST_W'(1);
          end
          S_UPDATE: begin
            wk.count <= remain_after;
            if (wk.inc_src) wk.src_lo <= wk.src_lo + 16'(blen);
            if (wk.inc_dst) wk.dst_lo <= wk.dst_lo + 16'(blen);
            if (term_hit || remain_after == '0) state <= S_FINISH;
            else if (cfg_req_per_burst)          state <= S_WAIT;
            else                                 state <= S_CHECK;
          end
          S_WAIT: if (take) state <= S_CHECK;
          S_FINISH: begin
            if (chain_end) begin
              cur_idx <= cfg_init_desc;
              state   <= S_IDLE;
            end else begin
              cur_idx <= IDX_W'(wk.next);
              state   <= wk.auto_next ? S_LOAD : S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req  = (state == S_READ) || (state == S_WRITE);
  assign mem_we   = (state == S_WRITE);
  assign mem_addr = mem_we ? {cfg_dst_hi, wk.dst_lo + 16'(k)}
                           : {cfg_src_hi, wk.src_lo + 16'(k)};
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk import dmac_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               bus_grant,
  input logic               mem_req,
  input logic               mem_we,
  input logic [31:0]        mem_addr,
  input logic [15:0]        cfg_src_hi,
  input logic [15:0]        cfg_dst_hi,
  input logic [BURST_W-1:0] cfg_burst,
  input logic [BURST_W-1:0] burst_len,
  input logic               done
);
  AST_SRC_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we) |-> mem_addr[31:16] == cfg_src_hi); // R1
  AST_DST_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> mem_addr[31:16] == cfg_dst_hi); // R1
  AST_READ_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we && $past(mem_req && !mem_we)) |-> mem_addr[15:0] == $past(mem_addr[15:0]) + 16'd1); // R3
  AST_WRITE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && $past(mem_req && mem_we)) |-> mem_addr[15:0] == $past(mem_addr[15:0]) + 16'd1); // R3
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_req) |-> $past(bus_grant)); // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we) |-> $past(mem_req && !mem_we)); // R3
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> (burst_len != '0) && (cfg_burst == '0 || burst_len <= cfg_burst)); // R3
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !mem_req); // R13
  AST_DONE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |=> done ##1 !done); // R10
endmodule

bind dmac_chan dmac_chan_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .bus_grant  (bus_grant),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cfg_src_hi (cfg_src_hi),
  .cfg_dst_hi (cfg_dst_hi),
  .cfg_burst  (cfg_burst),
  .burst_len  (blen),
  .done       (done)
);

// File: tb/dmac_chan_tb.sv
`timescale 1ns/1ps
module dmac_chan_tb;
  localparam int DW = 59;
  localparam logic [15:0] SHI = 16'hA51C;
  localparam logic [15:0] DHI = 16'h3C07;
  // {count[11:0], burst[6:0], inc_src, inc_dst, swap_en, swap4}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {12'd8,  7'd1, 4'b1100},
    {12'd16, 7'd4, 4'b1110},
    {12'd16, 7'd4, 4'b1111},
    {12'd6,  7'd2, 4'b0100},
    {12'd8,  7'd2, 4'b1000},
    {12'd10, 7'd4, 4'b1100}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, req = 1'b0, term_in = 1'b0, bus_grant = 1'b1;
  logic [6:0] cfg_burst = 7'd1;
  logic cfg_rpb = 1'b0, cfg_preserve = 1'b1, dw_en = 1'b0;
  logic [3:0] dw_idx = '0;
  logic [DW-1:0] dw_data = '0;
  logic mem_req, mem_we, done;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] bmem [1024];
  logic [7:0] expb [64];
  int checks = 0, fails = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, bad_hi = 0, done_rises = 0, done_hi = 0;
  logic done_prev = 1'b0;

  always #4 clk = ~clk;

  dmac_chan u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req(req), .term_in(term_in),
    .bus_grant(bus_grant), .cfg_src_hi(SHI), .cfg_dst_hi(DHI), .cfg_burst(cfg_burst),
    .cfg_req_per_burst(cfg_rpb), .cfg_init_desc(4'd0), .cfg_preserve(cfg_preserve),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
  );

  assign mem_rdata = bmem[mem_addr[9:0]];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req && mem_we) begin
        bmem[mem_addr[9:0]] = mem_wdata;
        wr_cnt++;
        if (mem_addr[31:16] != DHI) bad_hi++;
      end
      if (mem_req && !mem_we) begin
        rd_cnt++;
        if (mem_addr[31:16] != SHI) bad_hi++;
      end
      if (done) done_hi++;
      if (done && !done_prev) done_rises++;
    end
    done_prev = done;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 layout: {next, count, src, dst, flags[6:0]}
  task automatic prog(input int idx, input logic [7:0] nxt, input logic [11:0] cnt,
                      input logic [15:0] s, input logic [15:0] d, input logic [6:0] fl);
    @(negedge clk);
    dw_en = 1'b1; dw_idx = 4'(idx); dw_data = {nxt, cnt, s, d, fl};
    @(negedge clk);
    dw_en = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 600) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, n, 0);
    idle(4);
  endtask

  task automatic fill();
    for (int i = 0; i < 1024; i++) bmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
  endtask

  int w0, r0, dr0, dh0, bad;

  initial begin
    fill();
    idle(3);
    // R14: reset state
    chk(mem_req == 1'b0, "R14 mem_req in reset", int'(mem_req), 0);
    chk(done == 1'b0, "R14 done in reset", int'(done), 0);
    rst_n = 1'b1;
    idle(2);
    enable = 1'b1;

    // Vector table: single descriptor, one request, no per-burst requests
    for (int v = 0; v < NV; v++) begin
      logic [11:0] cnt; logic [6:0] bl; logic is_, id_, sw, s4;
      int grp, got, sofs, dofs, len, si;
      {cnt, bl, is_, id_, sw, s4} = VEC[v];
      for (int i = 0; i < 64; i++) begin
        bmem[12'h100 + i] = 8'(i * 13 + v * 29 + 5);
        bmem[12'h200 + i] = 8'h00;
        expb[i] = 8'h00;
      end
      got = 0; sofs = 0; dofs = 0; grp = s4 ? 4 : 2;
      while (got < int'(cnt)) begin
        len = (int'(cnt) - got < int'(bl)) ? int'(cnt) - got : int'(bl);
        for (int j = 0; j < len; j++) begin
          si = sw ? (j / grp) * grp + (grp - 1 - j % grp) : j;
          expb[dofs + j] = bmem[12'h100 + sofs + si];
        end
        got += len;
        if (is_) sofs += len;
        if (id_) dofs += len;
      end
      cfg_burst = bl; cfg_rpb = 1'b0; cfg_preserve = 1'b1;
      prog(0, 8'hFE, cnt, 16'h0100, 16'h0200, {1'b0, 1'b1, 1'b0, s4, sw, id_, is_});
      w0 = wr_cnt;
      pulse_req();
      wait_done("R10 done after vector");
      chk(wr_cnt - w0 == int'(cnt), "R4 bytes written", wr_cnt - w0, int'(cnt));
      bad = 0;
      for (int i = 0; i < 64; i++) if (bmem[12'h200 + i] != expb[i]) bad++;
      // R2 R3 R6 R7: destination image
      chk(bad == 0, (v == 1 || v == 2) ? "R7 swapped image" : (v == 3 || v == 4) ? "R6 stepping image" : "R3 burst image", bad, 0);
    end

    // R5: request per burst
    cfg_burst = 7'd2; cfg_rpb = 1'b1;
    prog(0, 8'hFE, 12'd4, 16'h0100, 16'h0280, 7'b0100011);
    w0 = wr_cnt; dr0 = done_rises;
    pulse_req(); idle(30);
    chk(wr_cnt - w0 == 2, "R5 one burst per request", wr_cnt - w0, 2);
    chk(done_rises == dr0, "R5 no done mid-descriptor", done_rises - dr0, 0);
    pulse_req(); wait_done("R5 done after second request");
    chk(wr_cnt - w0 == 4, "R5 second burst", wr_cnt - w0, 4);
    cfg_rpb = 1'b0;

    // R12 + R10: zero count, done width
    prog(0, 8'hFE, 12'd0, 16'h0100, 16'h0280, 7'b0100011);
    w0 = wr_cnt; r0 = rd_cnt; dh0 = done_hi;
    pulse_req(); wait_done("R12 zero-count done"); idle(4);
    chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R12 no bus access", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk(done_hi - dh0 == 2, "R10 done two cycles", done_hi - dh0, 2);

    // R8: auto chaining
    prog(0, 8'h01, 12'd2, 16'h0100, 16'h0240, 7'b0010011);
    prog(1, 8'hFE, 12'd2, 16'h0104, 16'h0250, 7'b0100011);
    w0 = wr_cnt; dr0 = done_rises;
    pulse_req(); wait_done("R8 auto chain done");
    chk(wr_cnt - w0 == 4, "R8 auto chain bytes", wr_cnt - w0, 4);
    chk(done_rises - dr0 == 1, "R8 one done pulse", done_rises - dr0, 1);
    chk(bmem[12'h251] == bmem[12'h105], "R8 second descriptor data", int'(bmem[12'h251]), int'(bmem[12'h105]));

    // R8: chaining without auto start
    prog(0, 8'h01, 12'd2, 16'h0100, 16'h0240, 7'b0000011);
    w0 = wr_cnt;
    pulse_req(); idle(30);
    chk(wr_cnt - w0 == 2, "R8 waits for request", wr_cnt - w0, 2);
    pulse_req(); wait_done("R8 second descriptor done");
    chk(wr_cnt - w0 == 4, "R8 after second request", wr_cnt - w0, 4);

    // R9: preserve clear overwrites the descriptor
    cfg_preserve = 1'b0;
    prog(0, 8'hFE, 12'd4, 16'h0100, 16'h0260, 7'b0100011);
    w0 = wr_cnt;
    pulse_req(); wait_done("R9 first run");
    pulse_req(); wait_done("R9 rerun done");
    chk(wr_cnt - w0 == 4, "R9 overwritten count is zero", wr_cnt - w0, 4);
    // R9: preserve set replays
    cfg_preserve = 1'b1;
    prog(0, 8'hFE, 12'd4, 16'h0100, 16'h0260, 7'b0100011);
    w0 = wr_cnt;
    pulse_req(); wait_done("R9 preserved run 1");
    pulse_req(); wait_done("R9 preserved run 2");
    chk(wr_cnt - w0 == 8, "R9 replay", wr_cnt - w0, 8);

    // R11: termination input during second burst
    cfg_burst = 7'd2;
    prog(0, 8'hFE, 12'd8, 16'h0100, 16'h0270, 7'b1100011);
    w0 = wr_cnt;
    pulse_req();
    begin
      int n = 0;
      while (!(wr_cnt - w0 == 2 && mem_req && !mem_we) && n < 200) begin @(negedge clk); n++; end
    end
    term_in = 1'b1; idle(2); term_in = 1'b0;
    wait_done("R11 early done");
    chk(wr_cnt - w0 == 4, "R11 ends after current burst", wr_cnt - w0, 4);

    // R3: grant held low
    bus_grant = 1'b0;
    prog(0, 8'hFE, 12'd2, 16'h0100, 16'h0270, 7'b0100011);
    w0 = wr_cnt; r0 = rd_cnt;
    pulse_req(); idle(20);
    chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R3 waits for grant", (wr_cnt - w0) + (rd_cnt - r0), 0);
    bus_grant = 1'b1;
    wait_done("R3 proceeds after grant");
    chk(wr_cnt - w0 == 2, "R3 bytes after grant", wr_cnt - w0, 2);

    // R13: requests while disabled are dropped
    enable = 1'b0;
    w0 = wr_cnt; r0 = rd_cnt;
    pulse_req(); idle(3);
    enable = 1'b1; idle(20);
    chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R13 request ignored", (wr_cnt - w0) + (rd_cnt - r0), 0);
    pulse_req(); wait_done("R13 re-armed");
    chk(wr_cnt - w0 == 2, "R13 runs after re-enable", wr_cnt - w0, 2);

    // R1: upper address halves
    chk(bad_hi == 0, "R1 upper address halves", bad_hi, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule